// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. It is clocked by the test clock, and a sixteen-state controller steers it by the test mode select level sampled on each rising clock edge. A 4-bit instruction is shifted in serially and becomes active on its update step. The active instruction chooses which data register is placed between the serial input and the serial output during a data scan. The three data registers are a one-bit bypass stage, a 32-bit device identity word, and a boundary register whose length is set by a parameter.

The boundary register has three parts: a capture/shift stage that samples the parallel pin inputs, an update stage that holds preloaded values, and a pin multiplexer. Under the external-test instruction, the multiplexer drives the pins from the update stage. Under every other instruction, the functional core values reach the pins. The serial output changes on falling clock edges and carries an enable flag. That flag stands in for the high-impedance state outside the two shift states. An active-low asynchronous test reset returns everything to its idle condition.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller moves through the sixteen standard states on each rising `tck` edge, based only on `tms`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: While `trst_n` is low, the controller is in Test-Logic-Reset, `tdo_en` is 0, and `pin_out` equals `core_out`.
- R3: After Test-Logic-Reset, and until the first Update-IR, a data scan selects the identity register. The scan returns the 32-bit `IDCODE` parameter, bit 0 first. When `HAS_ID` is 0, the bypass register is selected instead.
- R4: Capture-IR loads the pattern 0001 into the instruction shift stage. Shift-IR moves the stage one bit per edge. `tdi` enters the MSB and bit 0 leaves first, so a scan returns 1,0,0,0 in that order.
- R5: The active instruction changes only on the Update-IR step (and on Test-Logic-Reset). While Shift-IR runs, the pins keep following the old instruction.
- R6: Opcode 4'b1111 selects the bypass register. It captures 0, so a data scan returns a 0 followed by `tdi` delayed by one edge.
- R7: Opcodes 4'b0010 through 4'b1110 are reserved and select the bypass register, which behaves as in R6.
- R8: Opcode 4'b0001 (sample/preload) selects the boundary register. Capture-DR samples `pin_in`, which is shifted out bit 0 first. Update-DR copies the shifted-in bits to `bsr_upd`. `pin_out` stays equal to `core_out`.
- R9: Opcode 4'b0000 (external test) selects the boundary register in the same way as R8, and `pin_out` equals `bsr_upd`.
- R10: `tdo` changes only on falling `tck` edges. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`; low means high impedance |
| pin_in | input | BSR_LEN | Pin levels sampled at Capture-DR |
| core_out | input | BSR_LEN | Functional values for the pins |
| pin_out | output | BSR_LEN | Values driven to the pins |
| bsr_upd | output | BSR_LEN | Boundary update stage |

## Verification
On every cycle, the assertions check four things: the five-ones escape to reset, the hold of the active instruction outside Update-IR, the capture patterns of the instruction stage and the bypass stage, and the match between the output enable and the two shift states. Some behaviour can only be shown by the bench's scans with random opcodes and data: the exact bit order out of each data register, the one-edge bypass delay, the pin multiplexing under each instruction, and the identity read after a reset in the middle of an operation.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DSEL_BYP, DSEL_ID, DSEL_BSR} dsel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_RTI;
      ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SHF_IR;
      default:   return tms ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic dsel_e op_decode(logic [IR_W-1:0] op);
    if (op == OP_EXTEST || op == OP_SAMPLE) return DSEL_BSR;
    return DSEL_BYP;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state    <= ST_TLR;
      ones_cnt <= '0;
    end else begin
      state    <= tap_next(state, tms);
      ones_cnt <= !tms ? 3'd0 : (ones_cnt == 3'd5 ? 3'd5 : ones_cnt + 3'd1);
    end
  end

  AST_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_TLR)); // R1

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
)(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output dsel_e      dsel,
  output logic       extest_on
);

  localparam dsel_e RST_SEL = HAS_ID ? DSEL_ID : DSEL_BYP;

  logic [IR_W-1:0] ir_sh, ir_act;
  logic cap_ir_evt, shf_ir_evt, upd_ir_evt, tlr_evt;

  assign cap_ir_evt = (state == ST_CAP_IR);
  assign shf_ir_evt = (state == ST_SHF_IR);
  assign upd_ir_evt = (state == ST_UPD_IR);
  assign tlr_evt    = (state == ST_TLR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh  <= IR_CAPTURE;
      ir_act <= OP_BYPASS;
      dsel   <= RST_SEL;
    end else begin
      if (tlr_evt) begin
        ir_act <= OP_BYPASS;
        dsel   <= RST_SEL;
      end else if (upd_ir_evt) begin
        ir_act <= ir_sh;
        dsel   <= op_decode(ir_sh);
      end
      if (cap_ir_evt)      ir_sh <= IR_CAPTURE;
      else if (shf_ir_evt) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  assign ir_lsb    = ir_sh[0];
  assign extest_on = (dsel == DSEL_BSR) && (ir_act == OP_EXTEST);

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ir_evt && !tlr_evt) |=> ($stable(ir_act) && $stable(dsel))); // R5
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir_evt |=> (ir_sh[1:0] == 2'b01)); // R4
  AST_RSVD_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_ir_evt && ir_sh != OP_EXTEST && ir_sh != OP_SAMPLE) |=> (dsel == DSEL_BYP)); // R7

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] IDCODE  = 32'h1A5C_E0F3
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dsel_e              dsel,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_upd
);

  localparam int ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic cap_dr_evt, shf_dr_evt, upd_dr_evt;

  assign cap_dr_evt = (state == ST_CAP_DR);
  assign shf_dr_evt = (state == ST_SHF_DR);
  assign upd_dr_evt = (state == ST_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q   <= 1'b0;
      id_sh   <= IDCODE;
      bsr_sh  <= '0;
      bsr_upd <= '0;
    end else begin
      if (cap_dr_evt) begin
        case (dsel)
          DSEL_ID:  id_sh  <= IDCODE;
          DSEL_BSR: bsr_sh <= pin_in;
          default:  byp_q  <= 1'b0;
        endcase
      end else if (shf_dr_evt) begin
        case (dsel)
          DSEL_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
          DSEL_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
          default:  byp_q  <= tdi;
        endcase
      end
      if (upd_dr_evt && dsel == DSEL_BSR) bsr_upd <= bsr_sh;
    end
  end

  always_comb begin
    case (dsel)
      DSEL_ID:  dr_lsb = id_sh[0];
      DSEL_BSR: dr_lsb = bsr_sh[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_evt && dsel == DSEL_BYP) |=> (byp_q == 1'b0)); // R6
  AST_BSR_UPD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd_dr_evt && dsel == DSEL_BSR) |=> $stable(bsr_upd)); // R8

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter bit          HAS_ID  = 1'b1,
  parameter logic [31:0] IDCODE  = 32'h1A5C_E0F3
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [BSR_LEN-1:0] pin_in,
  input  logic [BSR_LEN-1:0] core_out,
  output logic [BSR_LEN-1:0] pin_out,
  output logic [BSR_LEN-1:0] bsr_upd
);

  tap_state_e state;
  dsel_e      dsel;
  logic       ir_lsb, dr_lsb, extest_on, in_shift;

  jtag_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  jtag_tap_ir #(.HAS_ID(HAS_ID)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .dsel(dsel), .extest_on(extest_on));

  jtag_tap_dr #(.BSR_LEN(BSR_LEN), .IDCODE(IDCODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .dsel(dsel),
    .pin_in(pin_in), .dr_lsb(dr_lsb), .bsr_upd(bsr_upd));

  assign in_shift = (state == ST_SHF_IR) || (state == ST_SHF_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_shift;
      if (state == ST_SHF_IR)      tdo <= ir_lsb;
      else if (state == ST_SHF_DR) tdo <= dr_lsb;
    end
  end

  assign pin_out = extest_on ? bsr_upd : core_out;

  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == in_shift); // R10

endmodule

// File: tb/test_jtag_tap_ctrl.sv
module test_jtag_tap_ctrl;

  localparam int          L  = 8;
  localparam logic [31:0] ID = 32'h1A5C_E0F3;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;
  logic [L-1:0] pin_in = '0, core_out = '0, pin_out, bsr_upd;
  int n_run = 0, n_fail = 0;
  logic [3:0] mid_ir_out;
  logic [L-1:0] mid_pin;
  bit en_ok, edge_ok;

  always #10 tck = ~tck;

  jtag_tap_ctrl #(.BSR_LEN(L), .HAS_ID(1'b1), .IDCODE(ID)) i_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out), .bsr_upd(bsr_upd));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m);
    @(negedge tck); #2; tms = m;
    @(posedge tck); #1;
  endtask

  // shift n bits from the current shift state; leaves in Exit1
  task automatic shift_n(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #2;
      dout[i] = tdo;
      if (!tdo_en) en_ok = 1'b0;
      tms = (i == n - 1); tdi = din[i];
      if (i == 2) mid_pin = pin_out;
      @(posedge tck); #1;
      if (tdo !== dout[i]) edge_ok = 1'b0;
    end
  endtask

  task automatic scan_ir(input logic [3:0] op);
    logic [63:0] o;
    step(1); step(1); step(0); step(0);
    shift_n(4, {60'd0, op}, o);
    mid_ir_out = o[3:0];
    step(1); step(0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    step(1); step(0); step(0);
    shift_n(n, din, dout);
    step(1); step(0);
  endtask

  function automatic bit is_bsr(logic [3:0] op);
    return op == 4'b0000 || op == 4'b0001;
  endfunction

  function automatic logic [63:0] byp_expect(int n, logic [63:0] din);
    logic [63:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = din[i-1];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge tck);
    chk(1'b0, "WATCHDOG", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d, o;
    logic [3:0] op;
    void'($urandom(32'd1234));
    core_out = 8'h3C; pin_in = 8'h96;
    repeat (3) @(posedge tck);
    #5;
    chk(tdo_en == 1'b0, "R2 tdo_en in reset", 64'(tdo_en), 64'd0);
    chk(pin_out == core_out, "R2 pins in reset", 64'(pin_out), 64'(core_out));
    @(negedge tck); trst_n = 1'b1;
    step(0);
    chk(tdo_en == 1'b0, "R10 idle enable", 64'(tdo_en), 64'd0);

    en_ok = 1; edge_ok = 1;
    scan_dr(32, 64'hFFFF_FFFF, o);
    chk(o[31:0] == ID, "R3 id after reset", o, 64'(ID));
    chk(en_ok, "R10 enable in shift-dr", 64'(en_ok), 64'd1);
    chk(edge_ok, "R10 tdo on falling edge", 64'(edge_ok), 64'd1);

    scan_ir(4'b1111);
    chk(mid_ir_out == 4'b0001, "R4 capture-ir pattern", 64'(mid_ir_out), 64'd1);
    d = 64'h15;
    scan_dr(6, d, o);
    chk(o[5:0] == byp_expect(6, d)[5:0], "R6 bypass delay", o, byp_expect(6, d));

    scan_ir(4'b0111);
    d = 64'h2B;
    scan_dr(6, d, o);
    chk(o[5:0] == byp_expect(6, d)[5:0], "R7 reserved is bypass", o, byp_expect(6, d));

    scan_ir(4'b0001);
    pin_in = 8'hA5;
    scan_dr(L, 64'h5E, o);
    chk(o[L-1:0] == 8'hA5, "R8 sample capture", o, 64'hA5);
    chk(bsr_upd == 8'h5E, "R8 preload update", 64'(bsr_upd), 64'h5E);
    chk(pin_out == core_out, "R8 pins functional", 64'(pin_out), 64'(core_out));

    scan_ir(4'b0000);
    chk(pin_out == 8'h5E, "R9 extest drives preload", 64'(pin_out), 64'h5E);
    scan_ir(4'b0001);
    chk(mid_pin == 8'h5E, "R5 shift-ir keeps instruction", 64'(mid_pin), 64'h5E);
    chk(pin_out == core_out, "R5 update-ir switches", 64'(pin_out), 64'(core_out));

    // R1: five TMS-high edges from Shift-DR reach Test-Logic-Reset
    scan_ir(4'b1111);
    step(1); step(0); step(0);
    repeat (5) step(1);
    step(0);
    scan_dr(32, 64'd0, o);
    chk(o[31:0] == ID, "R1 five ones reset", o, 64'(ID));

    // R2: asynchronous reset in the middle of an operation
    scan_ir(4'b0000);
    step(1); step(0); step(0);
    @(negedge tck); #3; trst_n = 1'b0; #2;
    chk(tdo_en == 1'b0, "R2 async reset enable", 64'(tdo_en), 64'd0);
    chk(pin_out == core_out, "R2 async reset pins", 64'(pin_out), 64'(core_out));
    @(negedge tck); trst_n = 1'b1; tms = 1'b1;
    step(0);
    scan_dr(32, 64'd0, o);
    chk(o[31:0] == ID, "R3 id after trst", o, 64'(ID));

    for (int k = 0; k < 40; k++) begin
      op = 4'($urandom);
      if (k % 8 == 0) op = 4'b1111;
      pin_in = 8'($urandom);
      core_out = 8'($urandom);
      d = {$urandom, $urandom};
      en_ok = 1; edge_ok = 1;
      scan_ir(op);
      chk(mid_ir_out == 4'b0001, "R4 capture-ir pattern", 64'(mid_ir_out), 64'd1);
      if (is_bsr(op)) begin
        scan_dr(L, d, o);
        chk(o[L-1:0] == pin_in, op == 4'b0 ? "R9 capture" : "R8 capture", o, 64'(pin_in));
        chk(bsr_upd == d[L-1:0], "R8 update stage", 64'(bsr_upd), 64'(d[L-1:0]));
        if (op == 4'b0000)
          chk(pin_out == d[L-1:0], "R9 pins from update", 64'(pin_out), 64'(d[L-1:0]));
        else
          chk(pin_out == core_out, "R8 pins from core", 64'(pin_out), 64'(core_out));
      end else begin
        scan_dr(5, d, o);
        chk(o[4:0] == byp_expect(5, d)[4:0], op == 4'hF ? "R6 bypass" : "R7 reserved",
            o, byp_expect(5, d));
        chk(pin_out == core_out, "R7 pins from core", 64'(pin_out), 64'(core_out));
      end
      chk(en_ok && edge_ok, "R10 enable and edge", 64'({en_ok, edge_ok}), 64'd3);
      chk(tdo_en == 1'b0, "R10 idle enable", 64'(tdo_en), 64'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule